// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a 32-bit processor's load/store port and a memory-side burst port. It keeps 512 lines of 32 bytes (16 KiB). Each line has a tag, a valid bit and a dirty bit, and every address can live in exactly one line. A load or store that finds its line resident is served from the local array. Stores change only the cached copy and mark the line as modified.

When an access misses, the controller holds the processor by keeping `cpu_req_ready` low. If the resident line at that index is modified, it writes that line back as an 8-word burst. It then reads the whole new line as an 8-word burst, after which the held request completes as a hit. Stores that miss allocate the line in the same way.

A flush request names an address. If the line holding that address is resident and modified, the controller writes it back and leaves it resident and clean. Otherwise the flush completes at once.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address starts a read burst, and no memory request is pending.
- R2: Address bits [4:0] are the byte offset, bits [13:5] the line index and bits [31:14] the tag. Every memory burst address is line aligned: the index and tag of the line, with offset zero.
- R3: While a miss or write-back is in progress, `cpu_req_ready` stays low. The held request completes once its line is resident.
- R4: A load to a resident line is accepted in the cycle it is presented, with no memory traffic. `cpu_rsp_valid` is high with the word in the next cycle and at no other time.
- R5: A store to a resident line writes only the bytes whose `cpu_req_be` bit is set (bit n covers data bits 8n+7:8n) and issues no memory traffic.
- R6: A store that misses first fetches the line with one read burst. The store data then goes only into the cache, and no write burst occurs.
- R7: A miss to an index that holds a clean line with a different tag replaces that line with a read burst only. The displaced line misses again when it is next accessed.
- R8: A miss that displaces a modified line first writes the victim's 8 words to the victim's line address in ascending offset order. The read burst request is issued only after the last write beat.
- R9: A flush of a resident modified line writes it back and leaves it valid and clean, so a later access hits and a second flush makes no traffic. A flush of a clean or absent line completes without memory traffic.
- R10: Fill beats are stored at word offsets 0 to 7 in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_flush | input | 1 | Request is a line flush (overrides write) |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Burst request |
| mem_req_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | 32 | Line-aligned burst address |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | 32 | Write beat data |
| mem_wready | input | 1 | Memory takes the write beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The lookup is driven with several access patterns. A cold load separates a miss from a hit. Loads to other words of the same line show that the fill landed at the right offsets. A store with alternating byte enables shows whether the byte lanes merge correctly. Two addresses sharing an index are tried twice: once with a clean resident line, which shows that no needless write-back occurs, and once with a dirty one, which shows that the victim data and address reach memory before the refill. Flushes of a dirty line, of the same line again and of an absent line tell a real write-back apart from spurious traffic.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WB_REQ    = 3'd1,
        ST_WB_DATA   = 3'd2,
        ST_FILL_REQ  = 3'd3,
        ST_FILL_DATA = 3'd4
    } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int NUM_LINES = 512,
    parameter int TAG_W     = 18,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             fill_we,
    input  logic             set_dirty,
    input  logic             clr_dirty
);
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_we) begin
                valid_q[wr_idx] <= 1'b1;
                dirty_q[wr_idx] <= 1'b0;
            end else if (set_dirty) begin
                dirty_q[wr_idx] <= 1'b1;
            end else if (clr_dirty) begin
                dirty_q[wr_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
    parameter int DEPTH  = 4096,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) begin
                    mem_q[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/dcache_fsm.sv
module dcache_fsm
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 512,
    localparam int BE_W      = DATA_W / 8,
    localparam int WORDS     = LINE_BYTES / BE_W,
    localparam int WORD_W    = $clog2(WORDS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int BSEL_W    = $clog2(BE_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_valid,
    input  logic                    cpu_req_write,
    input  logic                    cpu_req_flush,
    input  logic [ADDR_W-1:BSEL_W]  cpu_word_addr,
    input  logic [DATA_W-1:0]       cpu_req_wdata,
    input  logic [BE_W-1:0]         cpu_req_be,
    output logic                    cpu_req_ready,
    output logic                    cpu_rsp_valid,
    output logic [DATA_W-1:0]       cpu_rsp_rdata,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_req_ready,
    output logic                    mem_wvalid,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_wready,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [IDX_W-1:0]        ts_rd_idx,
    input  logic [TAG_W-1:0]        ts_tag,
    input  logic                    ts_valid,
    input  logic                    ts_dirty,
    output logic [IDX_W-1:0]        ts_wr_idx,
    output logic [TAG_W-1:0]        ts_wr_tag,
    output logic                    ts_fill_we,
    output logic                    ts_set_dirty,
    output logic                    ts_clr_dirty,
    output logic [IDX_W+WORD_W-1:0] ds_raddr,
    input  logic [DATA_W-1:0]       ds_rdata,
    output logic                    ds_we,
    output logic [IDX_W+WORD_W-1:0] ds_waddr,
    output logic [DATA_W-1:0]       ds_wdata,
    output logic [BE_W-1:0]         ds_be
);
    typedef struct packed {
        dc_state_e         st;
        logic [WORD_W-1:0] beat;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic              flush;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctrl_t;

    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

    ctrl_t q, d;

    logic [WORD_W-1:0] req_word;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              hit;

    assign req_word = cpu_word_addr[BSEL_W +: WORD_W];
    assign req_idx  = cpu_word_addr[OFF_W +: IDX_W];
    assign req_tag  = cpu_word_addr[ADDR_W-1 -: TAG_W];

    assign cpu_rsp_valid = q.rsp_v;
    assign cpu_rsp_rdata = q.rsp_d;

    always_comb begin
        d             = q;
        d.rsp_v       = 1'b0;
        ts_rd_idx     = (q.st == ST_IDLE) ? req_idx : q.idx;
        hit           = ts_valid && (ts_tag == req_tag);
        cpu_req_ready = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {q.tag, q.idx, OFF_W'(0)};
        mem_wvalid    = 1'b0;
        mem_wdata     = ds_rdata;
        ts_wr_idx     = q.idx;
        ts_wr_tag     = q.tag;
        ts_fill_we    = 1'b0;
        ts_set_dirty  = 1'b0;
        ts_clr_dirty  = 1'b0;
        ds_raddr      = {q.idx, q.beat};
        ds_we         = 1'b0;
        ds_waddr      = {q.idx, q.beat};
        ds_wdata      = mem_rdata;
        ds_be         = '1;

        unique case (q.st)
            ST_IDLE: begin
                ds_raddr = {req_idx, req_word};
                if (cpu_req_valid) begin
                    if (cpu_req_flush) begin
                        if (hit && ts_dirty) begin
                            d.st    = ST_WB_REQ;
                            d.idx   = req_idx;
                            d.tag   = req_tag;
                            d.flush = 1'b1;
                        end else begin
                            cpu_req_ready = 1'b1;
                        end
                    end else if (hit) begin
                        cpu_req_ready = 1'b1;
                        if (cpu_req_write) begin
                            ds_we        = 1'b1;
                            ds_waddr     = {req_idx, req_word};
                            ds_wdata     = cpu_req_wdata;
                            ds_be        = cpu_req_be;
                            ts_wr_idx    = req_idx;
                            ts_set_dirty = 1'b1;
                        end else begin
                            d.rsp_v = 1'b1;
                            d.rsp_d = ds_rdata;
                        end
                    end else begin
                        d.idx   = req_idx;
                        d.tag   = req_tag;
                        d.flush = 1'b0;
                        d.st    = (ts_valid && ts_dirty) ? ST_WB_REQ : ST_FILL_REQ;
                    end
                end
            end
            ST_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {ts_tag, q.idx, OFF_W'(0)};
                if (mem_req_ready) begin
                    d.st   = ST_WB_DATA;
                    d.beat = '0;
                end
            end
            ST_WB_DATA: begin
                mem_wvalid = 1'b1;
                if (mem_wready) begin
                    d.beat = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        if (q.flush) begin
                            ts_clr_dirty = 1'b1;
                            d.st         = ST_IDLE;
                        end else begin
                            d.st = ST_FILL_REQ;
                        end
                    end
                end
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    d.st   = ST_FILL_DATA;
                    d.beat = '0;
                end
            end
            ST_FILL_DATA: begin
                if (mem_rvalid) begin
                    ds_we  = 1'b1;
                    d.beat = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        ts_fill_we = 1'b1;
                        d.st       = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 512,
    localparam int BE_W      = DATA_W / 8,
    localparam int WORDS     = LINE_BYTES / BE_W,
    localparam int WORD_W    = $clog2(WORDS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int BSEL_W    = $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic              cpu_req_flush,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    input  logic [BE_W-1:0]   cpu_req_be,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    output logic              mem_wvalid,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_wready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]        ts_rd_idx, ts_wr_idx;
    logic [TAG_W-1:0]        ts_tag, ts_wr_tag;
    logic                    ts_valid, ts_dirty;
    logic                    ts_fill_we, ts_set_dirty, ts_clr_dirty;
    logic [IDX_W+WORD_W-1:0] ds_raddr, ds_waddr;
    logic [DATA_W-1:0]       ds_rdata, ds_wdata;
    logic                    ds_we;
    logic [BE_W-1:0]         ds_be;

    dcache_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (ts_rd_idx),
        .rd_tag    (ts_tag),
        .rd_valid  (ts_valid),
        .rd_dirty  (ts_dirty),
        .wr_idx    (ts_wr_idx),
        .wr_tag    (ts_wr_tag),
        .fill_we   (ts_fill_we),
        .set_dirty (ts_set_dirty),
        .clr_dirty (ts_clr_dirty)
    );

    dcache_data_store #(
        .DEPTH  (NUM_LINES * WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk   (clk),
        .raddr (ds_raddr),
        .rdata (ds_rdata),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .be    (ds_be)
    );

    dcache_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_BYTES (LINE_BYTES),
        .NUM_LINES  (NUM_LINES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_flush (cpu_req_flush),
        .cpu_word_addr (cpu_req_addr[ADDR_W-1:BSEL_W]),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_req_be    (cpu_req_be),
        .cpu_req_ready (cpu_req_ready),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_wvalid    (mem_wvalid),
        .mem_wdata     (mem_wdata),
        .mem_wready    (mem_wready),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .ts_rd_idx     (ts_rd_idx),
        .ts_tag        (ts_tag),
        .ts_valid      (ts_valid),
        .ts_dirty      (ts_dirty),
        .ts_wr_idx     (ts_wr_idx),
        .ts_wr_tag     (ts_wr_tag),
        .ts_fill_we    (ts_fill_we),
        .ts_set_dirty  (ts_set_dirty),
        .ts_clr_dirty  (ts_clr_dirty),
        .ds_raddr      (ds_raddr),
        .ds_rdata      (ds_rdata),
        .ds_we         (ds_we),
        .ds_waddr      (ds_waddr),
        .ds_wdata      (ds_wdata),
        .ds_be         (ds_be)
    );
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORDS      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(WORDS) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic              cpu_req_flush,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_wvalid,
    input logic              mem_wready
);
    logic [CNT_W-1:0] wb_pend_q;
    logic             load_acc;

    assign load_acc = cpu_req_valid && cpu_req_ready && !cpu_req_write && !cpu_req_flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_pend_q <= '0;
        end else if (mem_req_valid && mem_req_ready && mem_req_write) begin
            wb_pend_q <= CNT_W'(WORDS);
        end else if (mem_wvalid && mem_wready && wb_pend_q != '0) begin
            wb_pend_q <= wb_pend_q - 1'b1;
        end
    end

    // R3
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_wvalid) |-> !cpu_req_ready);

    // R2
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    // R4
    rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc |=> cpu_rsp_valid);

    // R4
    rsp_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> $past(load_acc));

    // R8
    wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (wb_pend_q == '0));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

bind dcache_ctrl dcache_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .WORDS      (WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_flush (cpu_req_flush),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_wvalid    (mem_wvalid),
    .mem_wready    (mem_wready)
);

// File: tb/dcache_ctrl_test.sv
module dcache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0, cpu_req_flush = 1'b0;
    logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
    logic [3:0]  cpu_req_be = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid, mem_req_write, mem_wvalid;
    logic [31:0] mem_req_addr, mem_wdata;
    logic        mem_req_ready = 1'b0, mem_wready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int compared = 0, mismatched = 0;
    int rd_bursts = 0, wr_bursts = 0, seq = 0, last_rd_seq = 0, last_wr_seq = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [31:0] wr_words [8];
    logic [31:0] wmem [int unsigned];
    bit done = 0;

    always #2 clk = ~clk;

    dcache_ctrl uut (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (wmem.exists(a)) return wmem[a];
        return pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // memory model: serves one burst at a time
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                automatic logic [31:0] a = mem_req_addr;
                automatic logic        w = mem_req_write;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                seq++;
                if (w) begin
                    wr_bursts++; last_wr_addr = a; last_wr_seq = seq;
                    for (int i = 0; i < 8; i++) begin
                        wr_words[i] = mem_wdata;
                        wmem[a + 32'(4 * i)] = mem_wdata;
                        mem_wready = 1'b1;
                        @(negedge clk);
                    end
                    mem_wready = 1'b0;
                end else begin
                    rd_bursts++; last_rd_addr = a; last_rd_seq = seq;
                    @(negedge clk);
                    @(negedge clk);
                    for (int i = 0; i < 8; i++) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem_val(a + 32'(4 * i));
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic cpu_op(input bit wr, input bit fl, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int stall, output bit rsp);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_flush = fl;
        cpu_req_addr = a; cpu_req_wdata = wd; cpu_req_be = be;
        stall = 0;
        #1;
        while (!cpu_req_ready && stall < 200) begin
            @(negedge clk); #1; stall++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_flush = 1'b0;
        rsp = cpu_rsp_valid;
        rd  = cpu_rsp_rdata;
    endtask

    task automatic t_reset();
        check(!mem_req_valid && !mem_wvalid, "R1 idle memory port after reset", {31'd0, mem_req_valid}, 32'd0);
        check(!cpu_rsp_valid, "R1 no response after reset", {31'd0, cpu_rsp_valid}, 32'd0);
    endtask

    task automatic t_cold_miss();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts, w0 = wr_bursts;
        cpu_op(0, 0, 32'h0000_1234, '0, '0, rd, st, rsp);
        check(rd_bursts == r0 + 1, "R1 first access starts read burst", rd_bursts, r0 + 1);
        check(wr_bursts == w0, "R1 no write on cold miss", wr_bursts, w0);
        check(last_rd_addr == 32'h0000_1220, "R2 fill address line aligned", last_rd_addr, 32'h1220);
        check(st >= 8, "R3 stalled across whole fill", st, 8);
        check(rsp && rd == pat(32'h1234), "R3 held load completes with word", rd, pat(32'h1234));
    endtask

    task automatic t_hits();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts;
        cpu_op(0, 0, 32'h0000_1220, '0, '0, rd, st, rsp);
        check(st == 0 && rsp, "R4 load hit accepted at once", st, 0);
        check(rd == pat(32'h1220), "R10 offset 0 holds first beat", rd, pat(32'h1220));
        cpu_op(0, 0, 32'h0000_123C, '0, '0, rd, st, rsp);
        check(rd == pat(32'h123C), "R10 offset 7 holds last beat", rd, pat(32'h123C));
        check(rd_bursts == r0, "R4 hits make no memory traffic", rd_bursts, r0);
    endtask

    task automatic t_store_hit();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts, w0 = wr_bursts;
        logic [31:0] exp = (pat(32'h1238) & 32'hFF00_FF00) | (32'hDEAD_BEEF & 32'h00FF_00FF);
        cpu_op(1, 0, 32'h0000_1238, 32'hDEAD_BEEF, 4'b0101, rd, st, rsp);
        check(st == 0 && !rsp, "R5 store hit accepted without response", st, 0);
        cpu_op(0, 0, 32'h0000_1238, '0, '0, rd, st, rsp);
        check(rd == exp, "R5 byte-enable merge", rd, exp);
        check(rd_bursts == r0 && wr_bursts == w0, "R5 store hit makes no traffic", wr_bursts, w0);
    endtask

    task automatic t_store_miss();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts, w0 = wr_bursts;
        cpu_op(1, 0, 32'h1000_0000, 32'h1111_2222, 4'hF, rd, st, rsp);
        check(rd_bursts == r0 + 1 && last_rd_addr == 32'h1000_0000, "R6 store miss allocates by read", last_rd_addr, 32'h1000_0000);
        check(wr_bursts == w0, "R6 store miss writes no memory", wr_bursts, w0);
        cpu_op(0, 0, 32'h1000_0000, '0, '0, rd, st, rsp);
        check(rd == 32'h1111_2222 && st == 0, "R6 store data in cache", rd, 32'h1111_2222);
    endtask

    task automatic t_clean_conflict();
        logic [31:0] rd; int st; bit rsp; int r0, w0 = wr_bursts;
        cpu_op(0, 0, 32'h0000_0040, '0, '0, rd, st, rsp);
        r0 = rd_bursts;
        cpu_op(0, 0, 32'h0000_4040, '0, '0, rd, st, rsp);
        check(rd_bursts == r0 + 1 && rd == pat(32'h4040), "R7 conflicting line fetched", rd, pat(32'h4040));
        check(wr_bursts == w0, "R7 clean victim not written", wr_bursts, w0);
        cpu_op(0, 0, 32'h0000_0040, '0, '0, rd, st, rsp);
        check(rd_bursts == r0 + 2 && st >= 8, "R7 displaced line misses again", rd_bursts, r0 + 2);
    endtask

    task automatic t_dirty_evict();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts, w0 = wr_bursts;
        cpu_op(0, 0, 32'h1001_0000, '0, '0, rd, st, rsp);
        check(wr_bursts == w0 + 1 && last_wr_addr == 32'h1000_0000, "R8 victim written at its line", last_wr_addr, 32'h1000_0000);
        check(wr_words[0] == 32'h1111_2222, "R8 victim word 0 first", wr_words[0], 32'h1111_2222);
        check(wr_words[3] == pat(32'h1000_000C), "R8 victim words ascending", wr_words[3], pat(32'h1000_000C));
        check(rd_bursts == r0 + 1 && last_wr_seq < last_rd_seq, "R8 write-back precedes fill", last_rd_seq, last_wr_seq + 1);
        check(rd == pat(32'h1001_0000), "R8 new line data", rd, pat(32'h1001_0000));
        cpu_op(0, 0, 32'h1000_0000, '0, '0, rd, st, rsp);
        check(rd == 32'h1111_2222, "R8 evicted store reached memory", rd, 32'h1111_2222);
    endtask

    task automatic t_flush();
        logic [31:0] rd; int st; bit rsp; int r0 = rd_bursts, w0 = wr_bursts;
        logic [31:0] exp = (pat(32'h1238) & 32'hFF00_FF00) | (32'hDEAD_BEEF & 32'h00FF_00FF);
        cpu_op(0, 1, 32'h0000_1238, '0, '0, rd, st, rsp);
        check(wr_bursts == w0 + 1 && last_wr_addr == 32'h0000_1220, "R9 flush writes dirty line", last_wr_addr, 32'h1220);
        check(wr_words[6] == exp, "R9 flushed data", wr_words[6], exp);
        cpu_op(0, 0, 32'h0000_1238, '0, '0, rd, st, rsp);
        check(st == 0 && rd == exp && rd_bursts == r0, "R9 line stays valid after flush", rd, exp);
        cpu_op(0, 1, 32'h0000_1238, '0, '0, rd, st, rsp);
        check(wr_bursts == w0 + 1 && st == 0, "R9 second flush no traffic", wr_bursts, w0 + 1);
        cpu_op(0, 1, 32'h0000_7000, '0, '0, rd, st, rsp);
        check(wr_bursts == w0 + 1 && rd_bursts == r0 && st == 0, "R9 absent-line flush no traffic", wr_bursts, w0 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_miss();
        t_hits();
        t_store_hit();
        t_store_miss();
        t_clean_conflict();
        t_dirty_evict();
        t_flush();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule